// File: doc/BRIEF.md
# Byte-Mask Selected CRC Tag Generator

This block hashes a chosen subset of the leading bytes of every packet into a 32-bit flow tag. Packets arrive one byte per beat with start and end markers. On the start beat a 2-bit selector picks one of four byte masks, and each mask covers the first 128 byte offsets of the packet. Every byte whose mask bit is set is folded into a CRC-32 with polynomial 0x04C11DB7. The register port sets the CRC seed, the reflection and the final inversion.

The tag is presented with a one-cycle strobe. It comes after the beat at offset 127, or after the end-of-packet beat if the packet is shorter. Register writes may arrive at any time. A packet always uses the mask, seed and controls that were in force on its start beat.

Top module: `byte_mask_crc_tagger`

## Requirements
- R1: Mask m, offset o is enabled by register address m*16 + o/8, bit 7 - (o mod 8). Bit 7 therefore selects the lowest offset of its group of eight.
- R2: Only enabled bytes change the CRC. With a mask whose 16 registers are all zero, the tag equals the seed after the output transforms.
- R3: With reflect off, each enabled byte is shifted into a 32-bit register MSB first, polynomial 0x04C11DB7. The register starts from the seed, held little-endian at addresses 64 to 67.
- R4: With reflect on (address 68 bit 0), each byte is shifted in LSB first and the final register is bit-reversed.
- R5: With invert on (address 68 bit 1), the output is XORed with 0xFFFFFFFF.
- R6: `tag_valid` rises for one cycle in the cycle after the beat at offset 127, or after the end beat if that comes first. It fires once per packet.
- R7: Beats without a start marker that arrive after the tag was produced, or outside any packet, produce no tag.
- R8: In a packet shorter than the window, enabled offsets past its end are skipped. The tag follows the end beat and covers the bytes received.
- R9: Register writes made during a packet do not affect that packet. They apply from the next start beat.
- R10: A register read returns the last value written. Mask registers reset to 0, the seed resets to 0xFFFFFFFF and the control register resets to 0. Other addresses read as 0.
- R11: After reset `tag_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 7 | Register address (0-63 masks, 64-67 seed, 68 control) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| in_valid | input | 1 | Byte beat valid |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| in_sel | input | 2 | Mask index, sampled on the start beat |
| in_data | input | 8 | Packet byte |
| tag_valid | output | 1 | Tag strobe |
| tag | output | 32 | Flow tag |

## Verification
A corrupted snapshot mask or CRC register shows as a wrong tag value at the next strobe, at most one packet later. A stuck offset counter shows as a strobe at the wrong beat, or as a missing or repeated strobe, in the packet where it goes wrong. Known CRC-32 check values confirm the bit ordering for all four reflect/invert combinations. Writes made mid-packet confirm that a tag never mixes old and new settings.

// File: rtl/byte_mask_crc_tagger.sv
module byte_mask_crc_tagger #(
  parameter int          MASKS = 4,
  parameter int          MREGS = 16,
  parameter logic [31:0] POLY  = 32'h04C11DB7,
  localparam int NREG = MASKS * MREGS,
  localparam int ADRW = $clog2(NREG + 5),
  localparam int SELW = $clog2(MASKS)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [ADRW-1:0] cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic            in_valid,
  input  logic            in_sop,
  input  logic            in_eop,
  input  logic [SELW-1:0] in_sel,
  input  logic [7:0]      in_data,
  output logic            tag_valid,
  output logic [31:0]     tag
);
  localparam int WIN  = MREGS * 8;
  localparam int OFFW = $clog2(WIN);
  localparam int IDXW = $clog2(NREG);

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d, input logic lsb_first);
    logic b;
    for (int i = 0; i < 8; i++) begin
      b = lsb_first ? d[i] : d[7-i];
      c = {c[30:0], 1'b0} ^ ((c[31] ^ b) ? POLY : 32'h0);
    end
    return c;
  endfunction

  logic [7:0]      mreg [NREG];
  logic [31:0]     seed_r;
  logic            refl_r, inv_r;
  logic [ADRW-1:0] rel;
  assign rel = cfg_addr - ADRW'(NREG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mreg[i] <= '0;
      seed_r <= 32'hFFFF_FFFF;
      refl_r <= 1'b0;
      inv_r  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr < ADRW'(NREG)) mreg[cfg_addr[IDXW-1:0]] <= cfg_wdata;
      else if (rel < ADRW'(4))    seed_r[{rel[1:0], 3'b000} +: 8] <= cfg_wdata;
      else if (rel == ADRW'(4))   {inv_r, refl_r} <= cfg_wdata[1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < ADRW'(NREG)) cfg_rdata = mreg[cfg_addr[IDXW-1:0]];
    else if (rel < ADRW'(4))    cfg_rdata = seed_r[{rel[1:0], 3'b000} +: 8];
    else if (rel == ADRW'(4))   cfg_rdata = {6'b0, inv_r, refl_r};
  end

  logic [WIN-1:0] sel_mask;
  always_comb begin
    for (int j = 0; j < MREGS; j++)
      for (int b = 0; b < 8; b++)
        sel_mask[j*8+b] = mreg[IDXW'(int'(in_sel) * MREGS + j)][7-b];
  end

  logic [WIN-1:0]  act_mask;
  logic            act_refl, act_inv, busy;
  logic [31:0]     crc;
  logic [OFFW-1:0] cnt;

  logic            live, use_refl, use_inv, fire;
  logic [OFFW-1:0] off;
  logic [WIN-1:0]  use_mask;
  logic [31:0]     crc_in, crc_nx;

  assign live     = in_valid && (in_sop || busy);
  assign off      = in_sop ? '0 : cnt;
  assign use_mask = in_sop ? sel_mask : act_mask;
  assign use_refl = in_sop ? refl_r : act_refl;
  assign use_inv  = in_sop ? inv_r : act_inv;
  assign crc_in   = in_sop ? seed_r : crc;
  assign crc_nx   = use_mask[off] ? crc_step(crc_in, in_data, use_refl) : crc_in;
  assign fire     = live && (in_eop || off == OFFW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mask  <= '0;
      act_refl  <= 1'b0;
      act_inv   <= 1'b0;
      busy      <= 1'b0;
      crc       <= '0;
      cnt       <= '0;
      tag_valid <= 1'b0;
      tag       <= '0;
    end else begin
      tag_valid <= fire;
      if (live) begin
        crc  <= crc_nx;
        cnt  <= off + 1'b1;
        busy <= !fire;
        if (in_sop) begin
          act_mask <= sel_mask;
          act_refl <= refl_r;
          act_inv  <= inv_r;
        end
      end
      if (fire)
        tag <= (use_refl ? rev32(crc_nx) : crc_nx) ^ {32{use_inv}};
    end
  end

  AST_TAG_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> $past(in_valid)); // R6
  AST_EOP_GIVES_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_eop && (in_sop || busy)) |-> tag_valid); // R8
  AST_NO_STRAY_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sop && !busy) |=> !tag_valid); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(in_valid && in_sop)) |->
      ($stable(act_mask) && $stable(act_refl) && $stable(act_inv))); // R9
  AST_READ_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(cfg_addr) < ADRW'(NREG) && cfg_addr == $past(cfg_addr)) |->
      cfg_rdata == $past(cfg_wdata)); // R10
endmodule

// File: tb/byte_mask_crc_tagger_tb.sv
module byte_mask_crc_tagger_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [6:0] cfg_addr = 0; logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic in_valid = 0, in_sop = 0, in_eop = 0; logic [1:0] in_sel = 0; logic [7:0] in_data = 0;
  logic tag_valid; logic [31:0] tag;

  always #5 clk = ~clk;

  byte_mask_crc_tagger u_dut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_sel(in_sel), .in_data(in_data), .tag_valid(tag_valid), .tag(tag));

  int tests = 0, fails = 0;
  logic [7:0] sh [0:68];
  logic [7:0] pkt [0:255];
  logic [31:0] got; int fire_idx, fires;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  function automatic logic [31:0] model(input int sel, input int len);
    logic [31:0] c; logic refl, inv, b, fb;
    c = {sh[67], sh[66], sh[65], sh[64]}; refl = sh[68][0]; inv = sh[68][1];
    for (int o = 0; o < len && o < 128; o++)
      if (sh[sel*16 + o/8][7 - o%8])
        for (int k = 0; k < 8; k++) begin
          b = refl ? pkt[o][k] : pkt[o][7-k];
          fb = c[31] ^ b; c = {c[30:0], 1'b0};
          if (fb) c = c ^ 32'h04C11DB7;
        end
    if (refl) begin logic [31:0] r; for (int i = 0; i < 32; i++) r[i] = c[31-i]; c = r; end
    if (inv) c = ~c;
    return c;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 7'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0; sh[a] = d;
  endtask

  task automatic rd_check(input string req, input int a, input logic [7:0] exp);
    @(negedge clk); cfg_addr = 7'(a); #1 check(req, {24'b0, cfg_rdata}, {24'b0, exp});
  endtask

  task automatic send(input int sel, input int len, input int wr_at, input int wa, input logic [7:0] wd);
    fires = 0; fire_idx = -1; got = 'x;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1; in_sop = (i == 0); in_eop = (i == len-1); in_sel = 2'(sel); in_data = pkt[i];
      cfg_we = (i == wr_at); cfg_addr = 7'(wa); cfg_wdata = wd;
      @(posedge clk); #1;
      if (i == wr_at) sh[wa] = wd;
      if (tag_valid) begin fires++; if (fires == 1) begin got = tag; fire_idx = i; end end
    end
    @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0; cfg_we = 0;
    @(posedge clk); #1; if (tag_valid) fires++;
  endtask

  localparam logic [33:0] VEC [4] = '{
    {1'b0, 1'b0, 32'h0376E6E7}, {1'b0, 1'b1, 32'hFC891918},
    {1'b1, 1'b1, 32'hCBF43926}, {1'b1, 1'b0, 32'h340BC6D9}};

  initial begin
    #2000000; tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails); $finish;
  end

  initial begin
    logic [31:0] e;
    for (int i = 0; i < 69; i++) sh[i] = 8'h00;
    for (int i = 64; i < 68; i++) sh[i] = 8'hFF;
    repeat (3) @(posedge clk); @(negedge clk); rst_n = 1;
    #1 check("R11 tag_valid after reset", {31'b0, tag_valid}, 0);
    rd_check("R10 mask reset", 0, 8'h00);
    rd_check("R10 seed reset", 64, 8'hFF);
    rd_check("R10 ctl reset", 68, 8'h00);
    rd_check("R10 unmapped", 100, 8'h00);
    wr(5, 8'hA5); rd_check("R10 mask readback", 5, 8'hA5);
    wr(5, 8'h00);

    // R3 R4 R5: known CRC-32 check values over "123456789"
    for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
    wr(0, 8'hFF); wr(1, 8'h80);
    foreach (VEC[v]) begin
      wr(68, {6'b0, VEC[v][32], VEC[v][33]});
      send(0, 9, -1, 0, 0);
      check("R3/R4/R5 check value", got, VEC[v][31:0]);
      check("R6 fire at eop", 32'(fire_idx), 8);
      check("R6 single strobe", 32'(fires), 1);
    end

    // R9: mid-packet writes apply only from next packet
    wr(68, 8'h03);
    send(0, 9, 3, 68, 8'h00);
    check("R9 ctl write mid-packet", got, 32'hCBF43926);
    send(0, 9, -1, 0, 0);
    check("R9 new ctl next packet", got, 32'h0376E6E7);
    e = model(0, 9);
    send(0, 9, 2, 1, 8'h00);
    check("R9 mask write mid-packet", got, e);
    send(0, 9, -1, 0, 0);
    check("R9 new mask next packet", got, model(0, 9));

    // R1 / R2
    wr(64, 8'h78); wr(65, 8'h56); wr(66, 8'h34); wr(67, 8'h12); wr(68, 8'h00);
    for (int i = 0; i < 256; i++) pkt[i] = 8'(i*7 + 3);
    wr(33, 8'h01);
    send(2, 20, -1, 0, 0);
    check("R1 bit0 of reg 33 picks offset 15", got, model(2, 20));
    check("R1 not seed", {31'b0, got == 32'h12345678}, 0);
    send(1, 20, -1, 0, 0);
    check("R2 empty mask gives seed", got, 32'h12345678);
    wr(68, 8'h01);
    send(1, 20, -1, 0, 0);
    check("R2 R4 empty mask reflected seed", got, 32'h1E6A2C48);
    wr(68, 8'h00);
    for (int r = 32; r < 48; r++) wr(r, 8'h00);
    send(2, 20, -1, 0, 0);
    check("R2 cleared mask gives seed", got, 32'h12345678);

    // R6 / R7: long packet, window end at offset 127
    for (int i = 0; i < 256; i++) pkt[i] = 8'(i*13 + 1);
    wr(48, 8'h80); wr(63, 8'h01); wr(68, 8'h03);
    send(3, 140, -1, 0, 0);
    check("R6 fire after offset 127", 32'(fire_idx), 127);
    check("R7 one strobe for long packet", 32'(fires), 1);
    check("R6 long packet tag", got, model(3, 140));

    // R8: short packet
    send(3, 50, -1, 0, 0);
    check("R8 fire at eop", 32'(fire_idx), 49);
    check("R8 short packet tag", got, model(3, 50));

    // R7: stray beats outside any packet
    fires = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1; in_sop = 0; in_eop = (i == 2); in_data = 8'h55;
      @(posedge clk); #1; if (tag_valid) fires++;
    end
    @(negedge clk); in_valid = 0; in_eop = 0;
    @(posedge clk); #1; if (tag_valid) fires++;
    check("R7 stray beats no tag", 32'(fires), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule